// File: doc/BRIEF.md
# Input Rail Presence Probe

This block confirms that the switching converter's input rail is present before the buck controller is allowed to begin its soft-start ramp. Once the power-on-reset indication is released and the enable input is high, it sends short periodic turn-on requests to the high-side gate driver. While doing so it watches a single digital flag from an external switch-node comparator.

The comparator flag is resynchronised with two flops. Every change of its level, rising or falling, is counted. When the configured number of changes has been seen, the block raises a ready output that starts soft start. After that it stops probing.

Removing either the power-on-reset indication or the enable clears all progress. The analog comparator, the gate drivers and the power stage sit outside the block. With a 10 MHz clock, the default divider counts give a 1 µs request every 100 µs.

Top module: `vin_probe`

## Requirements
- R1: While rst_ni is low, hs_req_o, ready_o and edge_cnt_o are all zero.
- R2: While por_ok_i or en_i is low, hs_req_o, ready_o and edge_cnt_o read zero one clock later and stay at zero.
- R3: While probing, hs_req_o rises on the first clock after probing starts. It stays high for PULSE_CYC cycles, and its rising edges are PERIOD_CYC cycles apart.
- R4: A change of sw_high_i that is held stable is reflected in edge_cnt_o on the third rising clock edge after the change.
- R5: Rising and falling changes of sw_high_i each add one to edge_cnt_o.
- R6: ready_o rises on the same clock edge that edge_cnt_o reaches EDGES_REQ. ready_o then stays high while enabled, and edge_cnt_o holds at EDGES_REQ.
- R7: From the clock after ready_o rises, hs_req_o stays low, and further changes of sw_high_i leave edge_cnt_o unchanged.
- R8: Re-enabling after a disable restarts probing with a fresh period and a count of zero.
- R9: Changes of sw_high_i made while disabled are not counted, and enabling while the flag is high adds no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_ok_i | input | 1 | High when power-on reset has been released |
| en_i | input | 1 | High to enable, low to shut down |
| sw_high_i | input | 1 | Switch-node comparator flag, asynchronous |
| hs_req_o | output | 1 | High-side turn-on request pulse |
| ready_o | output | 1 | Input rail confirmed; starts soft start |
| edge_cnt_o | output | $clog2(EDGES_REQ+1) | Transitions counted so far |

## Verification
The flag is driven in several patterns:
- Isolated slow toggles separate the synchroniser latency from the counting.
- A toggle on every clock shows that each synchronised change counts once.
- Toggles applied while disabled, with the flag left high at enable, expose any spurious count or stale edge.
- Toggles after ready show that the count saturates and probing has stopped.

Repeated disable and re-enable with the probe period part-way through checks the restart alignment of the pulse train.

// File: rtl/probe_pkg.sv
package probe_pkg;
  typedef struct packed {
    logic clr;  // disabled: wipe all progress
    logic run;  // probing active
  } probe_ctl_t;
endpackage

// File: rtl/probe_sync.sv
module probe_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign edge_o  = s2_q ^ s3_q;
endmodule

// File: rtl/probe_pulse.sv
module probe_pulse #(
  parameter int PERIOD_CYC = 1000,
  parameter int PULSE_CYC  = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  probe_pkg::probe_ctl_t ctl_i,
  output logic                  pulse_o
);
  localparam int PH_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_CYC - 1);
  localparam logic [PH_W-1:0] PH_ON   = PH_W'(PULSE_CYC);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pulse_o <= 1'b0;
    end else if (ctl_i.clr) begin
      phase_q <= '0;
      pulse_o <= 1'b0;
    end else if (ctl_i.run) begin
      pulse_o <= (phase_q < PH_ON);
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
    end else begin
      pulse_o <= 1'b0;
    end
  end

  // R3
  pulse_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (phase_q >= PH_W'(1) && phase_q <= PH_ON));
endmodule

// File: rtl/probe_count.sv
module probe_count #(
  parameter int EDGES_REQ = 4,
  localparam int CNT_W = $clog2(EDGES_REQ + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  probe_pkg::probe_ctl_t ctl_i,
  input  logic                  edge_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  ready_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EDGES_REQ - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(EDGES_REQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      ready_o <= 1'b0;
    end else if (ctl_i.clr) begin
      cnt_o   <= '0;
      ready_o <= 1'b0;
    end else if (ctl_i.run && edge_i) begin
      cnt_o <= cnt_o + CNT_W'(1);
      if (cnt_o == CNT_LAST) ready_o <= 1'b1;
    end
  end

  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.clr && ctl_i.run && edge_i) |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  // R6
  ready_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cnt_o == CNT_FULL);
  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_FULL);
endmodule

// File: rtl/vin_probe.sv
module vin_probe #(
  parameter int PERIOD_CYC = 1000,
  parameter int PULSE_CYC  = 10,
  parameter int EDGES_REQ  = 4,
  localparam int CNT_W = $clog2(EDGES_REQ + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ok_i,
  input  logic             en_i,
  input  logic             sw_high_i,
  output logic             hs_req_o,
  output logic             ready_o,
  output logic [CNT_W-1:0] edge_cnt_o
);
  probe_pkg::probe_ctl_t ctl;
  logic sw_lvl, sw_edge;

  assign ctl.clr = !(por_ok_i && en_i);
  assign ctl.run = !ctl.clr && !ready_o;

  probe_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sw_high_i),
    .level_o(sw_lvl),
    .edge_o (sw_edge)
  );

  probe_pulse #(.PERIOD_CYC(PERIOD_CYC), .PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl),
    .pulse_o(hs_req_o)
  );

  probe_count #(.EDGES_REQ(EDGES_REQ)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl),
    .edge_i (sw_edge),
    .cnt_o  (edge_cnt_o),
    .ready_o(ready_o)
  );

  // R2
  off_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.clr |=> (edge_cnt_o == '0 && !ready_o && !hs_req_o));
  // R7
  quiet_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> !hs_req_o);
  // R7
  hold_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o) && !ctl.clr) |=> $stable(edge_cnt_o));
endmodule

// File: tb/sim_vin_probe.sv
module sim_vin_probe;
  localparam int P = 20, W = 3, N = 4;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0, rst_n = 1'b0, por = 1'b0, en = 1'b0, flag = 1'b0;
  logic hs, rdy;
  logic [CW-1:0] cnt;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  vin_probe #(.PERIOD_CYC(P), .PULSE_CYC(W), .EDGES_REQ(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_ok_i(por), .en_i(en),
    .sw_high_i(flag), .hs_req_o(hs), .ready_o(rdy), .edge_cnt_o(cnt));

  // behavioural reference
  int hist[$];
  int m_ph, m_cnt;
  bit m_pulse, m_rdy;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {0, 0, 0};
      m_ph = 0; m_cnt = 0; m_pulse = 0; m_rdy = 0;
    end else begin
      bit chg;
      chg = (hist[1] != hist[2]);
      hist.push_front(int'(flag));
      void'(hist.pop_back());
      if (!(por && en)) begin
        m_ph = 0; m_cnt = 0; m_pulse = 0; m_rdy = 0;
      end else if (!m_rdy) begin
        m_pulse = (m_ph < W);
        m_ph = (m_ph + 1) % P;
        if (chg) begin
          m_cnt++;
          if (m_cnt == N) m_rdy = 1;
        end
      end else begin
        m_pulse = 0;
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (hs !== m_pulse) begin errors++; $display("FAIL R3 hs_req_o=%0b expected %0b at %0t", hs, m_pulse, $time); end
    if (cnt !== CW'(m_cnt)) begin errors++; $display("FAIL R5 edge_cnt_o=%0d expected %0d at %0t", cnt, m_cnt, $time); end
    if (rdy !== m_rdy) begin errors++; $display("FAIL R6 ready_o=%0b expected %0b at %0t", rdy, m_rdy, $time); end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic toggle(input int gap);
    flag = ~flag;
    cyc(gap);
  endtask

  initial begin
    int hi;
    cyc(3);
    chk("R1 hs", int'(hs), 0); chk("R1 rdy", int'(rdy), 0); chk("R1 cnt", int'(cnt), 0);
    rst_n = 1'b1;
    por = 1'b1;
    cyc(2);
    // R9: toggles while disabled
    toggle(5); toggle(5); toggle(5);
    chk("R9 cnt disabled", int'(cnt), 0);
    chk("R2 no pulse disabled", int'(hs), 0);
    // enable with flag high: no stale count (R9)
    en = 1'b1;
    cyc(1);
    chk("R3 first pulse", int'(hs), 1);
    hi = 1;
    for (int i = 1; i < 2 * P; i++) begin cyc(1); hi += int'(hs); end
    chk("R3 high cycles over two periods", hi, 2 * W);
    chk("R9 no count at enable", int'(cnt), 0);
    // R4 latency
    flag = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R4 not yet at 2nd edge", int'(cnt), 0);
    @(posedge clk); #1;
    chk("R4 counted at 3rd edge", int'(cnt), 1);
    cyc(4);
    toggle(6);
    chk("R5 rise and fall counted", int'(cnt), 2);
    // R8 disable mid-period and re-enable
    en = 1'b0;
    cyc(2);
    chk("R2 cleared count", int'(cnt), 0);
    chk("R2 no pulse", int'(hs), 0);
    en = 1'b1;
    cyc(1);
    chk("R8 pulse restarts", int'(hs), 1);
    // fast toggling: one change per clock
    toggle(1); toggle(1); toggle(1); toggle(1);
    cyc(4);
    chk("R6 ready after four", int'(rdy), 1);
    chk("R6 count holds", int'(cnt), N);
    hi = 0;
    for (int i = 0; i < 3 * P; i++) begin
      if (i % 7 == 0) flag = ~flag;
      cyc(1);
      hi += int'(hs);
    end
    chk("R7 no pulses after ready", hi, 0);
    chk("R7 count frozen", int'(cnt), N);
    // por drop clears (R2), then restart (R8)
    por = 1'b0;
    cyc(2);
    chk("R2 por clears ready", int'(rdy), 0);
    por = 1'b1;
    cyc(P / 2);
    toggle(8); toggle(8); toggle(8);
    chk("R8 partial count", int'(cnt), 3);
    chk("R8 not ready", int'(rdy), 0);
    toggle(8);
    chk("R6 ready again", int'(rdy), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule